// File: doc/BRIEF.md
# Page Coherence Directory Manager

This block is the central authority for a set of shared pages spread over several nodes. For every page it stores three things: a busy lock, a mask of the nodes that hold read-only copies, and the ID of the node that currently owns the page. Nodes send it read queries and write queries. The manager never handles page data. It tells the current owner to serve the requester, and before any write it first revokes every read-only copy. The requester's confirm message closes the transaction.

Queries go into an arrival-order queue of `FIFO_DEPTH` entries. The manager runs one transaction at a time, and a transaction locks its page from the moment it starts until its confirm arrives. A queued query therefore cannot start while any entry is locked. Confirms bypass the queue and are always accepted.

For a write, invalidates are sent one per cycle to the other copy holders. The manager then counts the acknowledgements that come back, and only when the count reaches zero does it clear the copy mask and send the write forward.

Top module: `dir_manager`

## Requirements
- R1: After reset every page is owned by node 0, has an empty copy mask and is unlocked; `inReady` is high and `outValid` is low.
- R2: A read query (type 0x1) from node n for page p produces one read-forward message (type 0x2) to the current owner of p. That message carries `outSrc`=n and `outPage`=p. Node n joins the copy mask of p.
- R3: A read keeps its page locked until a read confirm (type 0x3) arrives from the requester for that page. Until then no other queued query starts and no further message is sent.
- R4: A write query (type 0x4) from node w for page p produces one invalidate (type 0x5) to each copy holder of p other than w. The invalidates go out on consecutive cycles in ascending node order, each with `outSrc`=w.
- R5: The write forward (type 0x7) to the owner of p is sent only after an invalidate confirm (type 0x6) for p has arrived from every node that was invalidated. The copy mask of p is then empty.
- R6: A write whose copy mask holds no node other than the writer sends no invalidate and goes straight to the write forward.
- R7: A write confirm (type 0x8) from the writer for that page makes the writer the owner of the page and releases the lock.
- R8: Queries are served in arrival order from a queue of 4 entries. When the queue is full, `inReady` is low for a query type. Confirm types always see `inReady` high.
- R9: A confirm with the wrong type for the current phase, the wrong source node or the wrong page is ignored. It changes neither the directory nor the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming message valid |
| inReady | output | 1 | Incoming message accepted this cycle |
| inType | input | 4 | Incoming message type code |
| inSrc | input | NODE_W | Sending node |
| inPage | input | PAGE_W | Page index of incoming message |
| outValid | output | 1 | Outgoing message valid (one cycle) |
| outType | output | 4 | Outgoing message type code |
| outDst | output | NODE_W | Destination node |
| outSrc | output | NODE_W | Node that started the transaction |
| outPage | output | PAGE_W | Page index of outgoing message |

## Verification
A corrupted owner field shows up at the next forward for that page: that forward goes to the wrong destination, one cycle after the query is dequeued. A corrupted copy mask shows up in the invalidate list, as the wrong number of invalidates or the wrong order. A lock or acknowledge counter that releases too early shows up as a forward sent while confirms are still outstanding. A counter that never releases shows up as a stall, with no further message. Sequences with random owners, readers and writers, mixed with stray confirms and a full queue, bring each of these out within a few cycles of the faulty step.

// File: rtl/dirmgr_pkg.sv
package dirmgr_pkg;

  localparam logic [3:0] MSG_NONE       = 4'h0;
  localparam logic [3:0] MSG_RD_QUERY   = 4'h1;
  localparam logic [3:0] MSG_RD_FWD     = 4'h2;
  localparam logic [3:0] MSG_RD_CONF    = 4'h3;
  localparam logic [3:0] MSG_WR_QUERY   = 4'h4;
  localparam logic [3:0] MSG_INVAL      = 4'h5;
  localparam logic [3:0] MSG_INVAL_CONF = 4'h6;
  localparam logic [3:0] MSG_WR_FWD     = 4'h7;
  localparam logic [3:0] MSG_WR_CONF    = 4'h8;

  // strobes from control to datapath
  typedef struct packed {
    logic pop;
    logic startRead;
    logic startInv;
    logic sendInv;
    logic sendWf;
    logic finishRead;
    logic finishWrite;
  } CtrlStrobes;

endpackage

// File: rtl/dirmgr_datapath.sv
module dirmgr_datapath
  import dirmgr_pkg::*;
#(
  parameter int NODES = 4,
  parameter int PAGES = 8,
  parameter int DEPTH = 4,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNT_W  = $clog2(NODES + 1),
  localparam int FCNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  CtrlStrobes        stb,
  input  logic              inValid,
  input  logic [3:0]        inType,
  input  logic [NODE_W-1:0] inSrc,
  input  logic [PAGE_W-1:0] inPage,
  output logic              inReady,
  output logic              fifoEmpty,
  output logic              headIsWrite,
  output logic              invPending,
  output logic              ackZero,
  output logic              rcHit,
  output logic              wcHit,
  output logic              outValid,
  output logic [3:0]        outType,
  output logic [NODE_W-1:0] outDst,
  output logic [NODE_W-1:0] outSrc,
  output logic [PAGE_W-1:0] outPage,
  output logic [CNT_W-1:0]  ackCnt,
  output logic [FCNT_W-1:0] fifoCount,
  output logic [PAGES-1:0]  lockBits
);

  function automatic logic [CNT_W-1:0] countOnes(input logic [NODES-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  // ---------------- request queue ----------------
  logic              fifoWr   [DEPTH];
  logic [NODE_W-1:0] fifoSrc  [DEPTH];
  logic [PAGE_W-1:0] fifoPage [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              isQuery, isConf, fifoFull, push;

  assign isQuery   = (inType == MSG_RD_QUERY) || (inType == MSG_WR_QUERY);
  assign isConf    = (inType == MSG_RD_CONF) || (inType == MSG_INVAL_CONF) ||
                     (inType == MSG_WR_CONF);
  assign fifoFull  = (fifoCount == FCNT_W'(DEPTH));
  assign fifoEmpty = (fifoCount == '0);
  assign inReady   = isConf || !fifoFull;
  assign push      = inValid && inReady && isQuery;

  always_ff @(posedge clk) begin
    if (push) begin
      fifoWr[wrPtr]   <= (inType == MSG_WR_QUERY);
      fifoSrc[wrPtr]  <= inSrc;
      fifoPage[wrPtr] <= inPage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (push)    wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (stb.pop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      fifoCount <= fifoCount + FCNT_W'(push) - FCNT_W'(stb.pop);
    end
  end

  logic [NODE_W-1:0] headSrc;
  logic [PAGE_W-1:0] headPage;
  logic [NODES-1:0]  headBit;
  assign headIsWrite = fifoWr[rdPtr];
  assign headSrc     = fifoSrc[rdPtr];
  assign headPage    = fifoPage[rdPtr];
  assign headBit     = NODES'(1) << headSrc;

  // ---------------- directory ----------------
  logic [NODE_W-1:0] owner   [PAGES];
  logic [NODES-1:0]  copySet [PAGES];
  logic [NODES-1:0]  others;
  assign others = copySet[headPage] & ~headBit;

  // ---------------- transaction state ----------------
  logic [NODE_W-1:0] curReq;
  logic [PAGE_W-1:0] curPage;
  logic [NODES-1:0]  sendMask, ackMask;
  logic [NODE_W-1:0] invIdx;
  logic              icHit;

  always_comb begin
    invIdx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (sendMask[i]) invIdx = NODE_W'(i);
    end
  end

  assign invPending = |sendMask;
  assign ackZero    = (ackCnt == '0);
  assign rcHit = inValid && (inType == MSG_RD_CONF) && (inSrc == curReq) && (inPage == curPage);
  assign wcHit = inValid && (inType == MSG_WR_CONF) && (inSrc == curReq) && (inPage == curPage);
  assign icHit = inValid && (inType == MSG_INVAL_CONF) && (inPage == curPage) && ackMask[inSrc];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGES; i++) begin
        owner[i]   <= '0;
        copySet[i] <= '0;
      end
      lockBits <= '0;
      curReq   <= '0;
      curPage  <= '0;
      sendMask <= '0;
      ackMask  <= '0;
      ackCnt   <= '0;
    end else begin
      if (stb.pop) begin
        curReq  <= headSrc;
        curPage <= headPage;
      end
      if (stb.startRead) begin
        copySet[headPage]  <= copySet[headPage] | headBit;
        lockBits[headPage] <= 1'b1;
      end
      if (stb.startInv) begin
        lockBits[headPage] <= 1'b1;
        sendMask <= others;
        ackMask  <= others;
        ackCnt   <= countOnes(others);
      end
      if (stb.sendInv) sendMask[invIdx] <= 1'b0;
      if (icHit) begin
        ackMask[inSrc] <= 1'b0;
        ackCnt         <= ackCnt - 1'b1;
      end
      if (stb.sendWf) copySet[curPage] <= '0;
      if (stb.finishRead) lockBits[curPage] <= 1'b0;
      if (stb.finishWrite) begin
        lockBits[curPage] <= 1'b0;
        owner[curPage]    <= curReq;
      end
    end
  end

  // ---------------- outgoing message register ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outType  <= MSG_NONE;
      outDst   <= '0;
      outSrc   <= '0;
      outPage  <= '0;
    end else begin
      outValid <= 1'b0;
      if (stb.startRead) begin
        outValid <= 1'b1;
        outType  <= MSG_RD_FWD;
        outDst   <= owner[headPage];
        outSrc   <= headSrc;
        outPage  <= headPage;
      end else if (stb.sendInv) begin
        outValid <= 1'b1;
        outType  <= MSG_INVAL;
        outDst   <= invIdx;
        outSrc   <= curReq;
        outPage  <= curPage;
      end else if (stb.sendWf) begin
        outValid <= 1'b1;
        outType  <= MSG_WR_FWD;
        outDst   <= owner[curPage];
        outSrc   <= curReq;
        outPage  <= curPage;
      end
    end
  end

endmodule

// File: rtl/dirmgr_ctrl.sv
module dirmgr_ctrl
  import dirmgr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  input  logic       headIsWrite,
  input  logic       invPending,
  input  logic       ackZero,
  input  logic       rcHit,
  input  logic       wcHit,
  output CtrlStrobes stb,
  output logic       busy
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_INV, S_WRITE} PhaseT;
  PhaseT phase, phaseNext;

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    unique case (phase)
      S_IDLE: begin
        if (!fifoEmpty) begin
          stb.pop = 1'b1;
          if (headIsWrite) begin
            stb.startInv = 1'b1;
            phaseNext    = S_INV;
          end else begin
            stb.startRead = 1'b1;
            phaseNext     = S_READ;
          end
        end
      end
      S_READ: begin
        if (rcHit) begin
          stb.finishRead = 1'b1;
          phaseNext      = S_IDLE;
        end
      end
      S_INV: begin
        if (invPending) begin
          stb.sendInv = 1'b1;
        end else if (ackZero) begin
          stb.sendWf = 1'b1;
          phaseNext  = S_WRITE;
        end
      end
      S_WRITE: begin
        if (wcHit) begin
          stb.finishWrite = 1'b1;
          phaseNext       = S_IDLE;
        end
      end
      default: phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= S_IDLE;
    else       phase <= phaseNext;
  end

  assign busy = (phase != S_IDLE);

endmodule

// File: rtl/dir_manager.sv
module dir_manager
  import dirmgr_pkg::*;
#(
  parameter int NODES      = 4,
  parameter int PAGES      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [3:0]        inType,
  input  logic [NODE_W-1:0] inSrc,
  input  logic [PAGE_W-1:0] inPage,
  output logic              outValid,
  output logic [3:0]        outType,
  output logic [NODE_W-1:0] outDst,
  output logic [NODE_W-1:0] outSrc,
  output logic [PAGE_W-1:0] outPage
);

  localparam int CNT_W  = $clog2(NODES + 1);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  CtrlStrobes        stb;
  logic              fifoEmpty, headIsWrite, invPending, ackZero, rcHit, wcHit, busy;
  logic [CNT_W-1:0]  ackCnt;
  logic [FCNT_W-1:0] fifoCount;
  logic [PAGES-1:0]  lockBits;

  dirmgr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .headIsWrite(headIsWrite),
    .invPending(invPending), .ackZero(ackZero), .rcHit(rcHit), .wcHit(wcHit),
    .stb(stb), .busy(busy)
  );

  dirmgr_datapath #(.NODES(NODES), .PAGES(PAGES), .DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inValid(inValid), .inType(inType), .inSrc(inSrc), .inPage(inPage), .inReady(inReady),
    .fifoEmpty(fifoEmpty), .headIsWrite(headIsWrite), .invPending(invPending),
    .ackZero(ackZero), .rcHit(rcHit), .wcHit(wcHit),
    .outValid(outValid), .outType(outType), .outDst(outDst), .outSrc(outSrc), .outPage(outPage),
    .ackCnt(ackCnt), .fifoCount(fifoCount), .lockBits(lockBits)
  );

endmodule

module dirmgr_checker
  import dirmgr_pkg::*;
#(
  parameter int NODES = 4,
  parameter int PAGES = 8,
  parameter int DEPTH = 4,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNT_W  = $clog2(NODES + 1),
  localparam int FCNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic [3:0]        inType,
  input logic              outValid,
  input logic [3:0]        outType,
  input logic [NODE_W-1:0] outDst,
  input logic [NODE_W-1:0] outSrc,
  input logic [PAGE_W-1:0] outPage,
  input logic              busy,
  input logic [CNT_W-1:0]  ackCnt,
  input logic [FCNT_W-1:0] fifoCount,
  input logic [PAGES-1:0]  lockBits
);

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= FCNT_W'(DEPTH)); // R8

  AST_FULL_STALLS_QUERY: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == FCNT_W'(DEPTH) && (inType == MSG_RD_QUERY || inType == MSG_WR_QUERY))
      |-> !inReady); // R8

  AST_INVAL_SKIPS_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType == MSG_INVAL) |-> (outDst != outSrc)); // R4

  AST_FWD_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType == MSG_WR_FWD) |-> (ackCnt == '0)); // R5

  AST_MSG_PAGE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busy && lockBits[outPage])); // R3

  AST_SINGLE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lockBits)); // R3

  AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (lockBits == '0)); // R7

endmodule

bind dir_manager dirmgr_checker #(.NODES(NODES), .PAGES(PAGES), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .inType(inType),
  .outValid(outValid), .outType(outType), .outDst(outDst), .outSrc(outSrc), .outPage(outPage),
  .busy(busy), .ackCnt(ackCnt), .fifoCount(fifoCount), .lockBits(lockBits)
);

// File: tb/dir_manager_tb.sv
module dir_manager_tb;
  import dirmgr_pkg::*;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic       inReady;
  logic [3:0] inType;
  logic [1:0] inSrc;
  logic [2:0] inPage;
  logic       outValid;
  logic [3:0] outType;
  logic [1:0] outDst, outSrc;
  logic [2:0] outPage;

  always #5 clk = ~clk;

  dir_manager u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inType(inType),
    .inSrc(inSrc), .inPage(inPage), .outValid(outValid), .outType(outType),
    .outDst(outDst), .outSrc(outSrc), .outPage(outPage)
  );

  int total = 0;
  int bad = 0;
  int         mOwner [8];
  logic [3:0] mCs    [8];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic sendMsg(input logic [3:0] t, input int src, input int pg);
    @(negedge clk);
    inValid = 1'b1; inType = t; inSrc = src[1:0]; inPage = pg[2:0];
    @(posedge clk);
    #1;
    inValid = 1'b0; inType = MSG_NONE;
  endtask

  task automatic expectMsg(input logic [3:0] t, input int dst, input int src,
                           input int pg, input string req);
    int waited = 0;
    int exp, act;
    while (1) begin
      @(negedge clk);
      if (outValid) break;
      waited++;
      if (waited > 40) break;
    end
    exp = {t, dst[1:0], src[1:0], pg[2:0]};
    act = {outType, outDst, outSrc, outPage};
    if (!outValid) check(1'b0, req, "no message {type,dst,src,page}", 0, exp);
    else check(act == exp, req, "message {type,dst,src,page}", act, exp);
  endtask

  task automatic expectQuiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outValid) seen = 1'b1;
    end
    check(!seen, req, "unexpected message", int'(seen), 0);
  endtask

  task automatic serveRead(input int n, input int p, input string tag);
    expectMsg(MSG_RD_FWD, mOwner[p], n, p, tag);
    mCs[p] = mCs[p] | (4'b1 << n);
    sendMsg(MSG_RD_CONF, n, p);
  endtask

  task automatic serveWrite(input int n, input int p, input string tag);
    logic [3:0] others;
    int lowest;
    others = mCs[p] & ~(4'b1 << n);
    lowest = -1;
    for (int i = 3; i >= 0; i--) if (others[i]) lowest = i;
    for (int i = 0; i < 4; i++)
      if (others[i]) expectMsg(MSG_INVAL, i, n, p, (tag == "") ? "R4" : tag);
    for (int i = 3; i >= 0; i--) begin
      if (others[i]) begin
        if (i == lowest) expectQuiet(3, "R5");
        sendMsg(MSG_INVAL_CONF, i, p);
      end
    end
    expectMsg(MSG_WR_FWD, mOwner[p], n, p,
              (tag != "") ? tag : ((others != 0) ? "R5" : "R6"));
    mCs[p] = '0;
    sendMsg(MSG_WR_CONF, n, p);
    mOwner[p] = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 8; i++) begin mOwner[i] = 0; mCs[i] = '0; end
    rstN = 1'b0; inValid = 1'b0; inType = MSG_NONE; inSrc = '0; inPage = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);

    // R1: first read goes to node 0
    sendMsg(MSG_RD_QUERY, 2, 3);
    serveRead(2, 3, "R1");

    // R9 stray confirms during a read, R3 lock hold
    sendMsg(MSG_RD_QUERY, 1, 3);
    expectMsg(MSG_RD_FWD, 0, 1, 3, "R2");
    mCs[3] = mCs[3] | 4'b0010;
    sendMsg(MSG_WR_CONF, 1, 3);
    sendMsg(MSG_RD_CONF, 2, 3);
    sendMsg(MSG_RD_CONF, 1, 4);
    sendMsg(MSG_INVAL_CONF, 1, 3);
    expectQuiet(3, "R9");
    sendMsg(MSG_RD_QUERY, 0, 6);
    expectQuiet(4, "R3");
    sendMsg(MSG_RD_CONF, 1, 3);
    serveRead(0, 6, "R3");
    // owner of page 3 still node 0 after stray write confirm
    sendMsg(MSG_WR_QUERY, 3, 3);
    serveWrite(3, 3, "");
    // R7: new owner serves the next read
    sendMsg(MSG_RD_QUERY, 1, 3);
    serveRead(1, 3, "R7");

    // R6: empty copy mask goes straight to the write forward
    sendMsg(MSG_WR_QUERY, 0, 7);
    serveWrite(0, 7, "R6");
    // R6: writer is the only copy holder
    sendMsg(MSG_RD_QUERY, 2, 5);
    serveRead(2, 5, "R2");
    sendMsg(MSG_WR_QUERY, 2, 5);
    serveWrite(2, 5, "R6");

    // R8: fill the queue behind an open read
    sendMsg(MSG_RD_QUERY, 1, 0);
    expectMsg(MSG_RD_FWD, mOwner[0], 1, 0, "R2");
    mCs[0] = mCs[0] | 4'b0010;
    sendMsg(MSG_WR_QUERY, 2, 1);
    sendMsg(MSG_RD_QUERY, 3, 2);
    sendMsg(MSG_RD_QUERY, 0, 1);
    sendMsg(MSG_WR_QUERY, 3, 0);
    @(negedge clk);
    inValid = 1'b1; inType = MSG_RD_QUERY; inSrc = 2'd2; inPage = 3'd7;
    #1;
    check(inReady == 1'b0, "R8", "inReady for query when full", int'(inReady), 0);
    inType = MSG_RD_CONF;
    #1;
    check(inReady == 1'b1, "R8", "inReady for confirm when full", int'(inReady), 1);
    inValid = 1'b0; inType = MSG_NONE;
    expectQuiet(2, "R3");
    sendMsg(MSG_RD_CONF, 1, 0);
    serveWrite(2, 1, "R8");
    serveRead(3, 2, "R8");
    serveRead(0, 1, "R8");
    serveWrite(3, 0, "");

    // random mix
    for (int k = 0; k < 80; k++) begin
      int n, p;
      n = int'($urandom_range(3, 0));
      p = int'($urandom_range(7, 0));
      if ($urandom_range(2, 0) == 0) begin
        sendMsg(MSG_WR_QUERY, n, p);
        serveWrite(n, p, "");
      end else begin
        sendMsg(MSG_RD_QUERY, n, p);
        serveRead(n, p, "R2");
      end
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule